// File: doc/BRIEF.md
# Partitioned Endpoint FIFO Buffer Manager

This block carves per-endpoint byte FIFOs out of one shared buffer RAM. The RAM has a transmit half (dir 0, data going to the host) and a receive half (dir 1, data arriving from the host). Each half is 512 bytes by default. There are eight endpoints, and each has an independent FIFO slot in both halves, which gives sixteen slots. Slot number `dir*8 + ep` selects the bit in every per-slot status vector.

Software places a FIFO by writing one configuration word for a slot. The word holds an enable, a transfer type, a maximum packet size, a FIFO size in bytes and a base byte offset inside the half. The block checks each enabled slot against the placement rules and raises a per-slot error bit for any violation. A slot that is disabled or in error moves no data.

Data enters through a one-byte write strobe and leaves through a one-byte read strobe. A slot number is given with each strobe. There is no back-pressure on either port. Instead, the producer and the consumer watch the `fifo_full` and `fifo_empty` vectors. A beat sent to a full slot, or a read of an empty slot, is dropped and recorded in a sticky flag. Read data comes back on the cycle after the strobe, together with `rd_valid`.

Top module: `epbuf_mgr`

## Requirements
- R1: After reset every slot is disabled, and all of these are clear: `fifo_full`, `ovf_flag`, `udf_flag`, `cfg_err` and `rd_valid`. Every bit of `fifo_empty` is set.
- R2: A `cfg_valid` strobe stores the configuration of slot {`cfg_dir`,`cfg_ep`}, and the new configuration is visible on the next cycle. It also zeroes both pointers of that slot and clears that slot's overflow and underflow flags. A data strobe to the same slot in the same cycle is ignored.
- R3: Transfer types are encoded as 0 control, 1 isochronous, 2 bulk and 3 interrupt. An enabled endpoint-0 slot with any type other than 0 sets its `cfg_err` bit.
- R4: An enabled slot whose size is zero or is not a power of two sets its `cfg_err` bit.
- R5: An enabled slot whose size is less than twice its maximum packet size sets its `cfg_err` bit. A size exactly equal to twice the maximum packet size is legal.
- R6: An enabled slot sets its `cfg_err` bit in either of two cases: its base is not a multiple of its size, or base plus size is greater than 512.
- R7: Two enabled slots in the same direction whose byte ranges [base, base+size) intersect both set their `cfg_err` bit. Ranges that only touch do not conflict, and slots in different directions never conflict.
- R8: Bytes read from a slot come out in the order they were written. Each accepted read raises `rd_valid`, with the byte on `rd_data`, in the following cycle.
- R9: A byte is stored at address base OR (pointer mod size) within its direction's half. So traffic that wraps a slot several times keeps its data, and the data of neighbouring slots is never disturbed.
- R10: `stat_level` for the slot chosen by {`stat_dir`,`stat_ep`} equals accepted writes minus accepted reads. A slot's `fifo_full` bit is set when that count equals its size, and its `fifo_empty` bit is set when the count is zero.
- R11: A write to a full slot is dropped and sets that slot's sticky `ovf_flag` bit. A read of an empty slot is dropped, leaves `rd_valid` low, and sets that slot's sticky `udf_flag` bit.
- R12: A write or read to a slot that is disabled, or whose `cfg_err` bit is set, changes nothing and sets no flag.
- R13: The same endpoint number in dir 0 and dir 1 names two independent slots with separate pointers and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_dir | input | 1 | Direction of the slot being configured |
| cfg_ep | input | 3 | Endpoint of the slot being configured |
| cfg_en | input | 1 | Slot enable |
| cfg_type | input | 2 | Transfer type (0 control, 1 isochronous, 2 bulk, 3 interrupt) |
| cfg_maxpkt | input | 10 | Maximum packet size in bytes |
| cfg_size | input | 11 | FIFO size in bytes |
| cfg_base | input | 9 | FIFO base byte offset within the half |
| wr_en | input | 1 | Write strobe |
| wr_dir | input | 1 | Write slot direction |
| wr_ep | input | 3 | Write slot endpoint |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_dir | input | 1 | Read slot direction |
| rd_ep | input | 3 | Read slot endpoint |
| rd_valid | output | 1 | Read byte valid (one cycle after an accepted read) |
| rd_data | output | 8 | Read byte |
| stat_dir | input | 1 | Direction of the slot whose level is reported |
| stat_ep | input | 3 | Endpoint of the slot whose level is reported |
| stat_level | output | 10 | Byte count of the selected slot |
| fifo_full | output | 16 | Per-slot full |
| fifo_empty | output | 16 | Per-slot empty |
| ovf_flag | output | 16 | Per-slot sticky overflow |
| udf_flag | output | 16 | Per-slot sticky underflow |
| cfg_err | output | 16 | Per-slot configuration error |

## Verification
The block updates the configuration registers, pointers and sticky flags on the clock edge that samples the strobe. So `cfg_err`, `fifo_full`, `fifo_empty`, `stat_level` and the flags all hold their new values one cycle after the strobe. `rd_valid` and `rd_data` also appear one cycle after the read strobe, because the RAM read is registered.

The bench drives every strobe for one cycle starting at a falling edge. It samples at the next falling edge, which is exactly one rising edge later. Combinational status reads are taken shortly after the select lines change.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  typedef enum logic [1:0] {
    XFER_CTRL = 2'd0,
    XFER_ISO  = 2'd1,
    XFER_BULK = 2'd2,
    XFER_INTR = 2'd3
  } xfer_e;
endpackage

// File: rtl/epbuf_ram.sv
module epbuf_ram #(
  parameter int DW = 8,
  parameter int RAW = 10,
  localparam int DEPTH = 1 << RAW
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/epbuf_cfg.sv
module epbuf_cfg
  import epbuf_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int HALF_BYTES = 512,
  localparam int AW = $clog2(HALF_BYTES),
  localparam int PW = AW + 1,
  localparam int SZW = AW + 2,
  localparam int EW = SZW + 1,
  localparam int SLOTS = 2 * NUM_EP,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [SW-1:0] cfg_slot,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_type,
  input  logic [PW-1:0] cfg_maxpkt,
  input  logic [SZW-1:0] cfg_size,
  input  logic [AW-1:0] cfg_base,
  output logic          slot_en   [SLOTS],
  output logic [PW-1:0] slot_size [SLOTS],
  output logic [AW-1:0] slot_base [SLOTS],
  output logic          slot_err  [SLOTS]
);
  logic           en_q   [SLOTS];
  xfer_e          type_q [SLOTS];
  logic [PW-1:0]  pkt_q  [SLOTS];
  logic [SZW-1:0] size_q [SLOTS];
  logic [AW-1:0]  base_q [SLOTS];
  logic [EW-1:0]  end_w  [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        en_q[i]   <= 1'b0;
        type_q[i] <= XFER_CTRL;
        pkt_q[i]  <= '0;
        size_q[i] <= '0;
        base_q[i] <= '0;
      end
    end else if (cfg_valid) begin
      en_q[cfg_slot]   <= cfg_en;
      type_q[cfg_slot] <= xfer_e'(cfg_type);
      pkt_q[cfg_slot]  <= cfg_maxpkt;
      size_q[cfg_slot] <= cfg_size;
      base_q[cfg_slot] <= cfg_base;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int EPI = s % NUM_EP;
    localparam int DBASE = (s / NUM_EP) * NUM_EP;
    logic [SZW-1:0] size_m1;
    logic type_bad, pow2_bad, pkt_bad, align_bad, over_bad, ovl_bad;

    assign end_w[s]  = EW'(base_q[s]) + EW'(size_q[s]);
    assign size_m1   = size_q[s] - SZW'(1);
    assign type_bad  = (EPI == 0) && (type_q[s] != XFER_CTRL);
    assign pow2_bad  = (size_q[s] == '0) || ((size_q[s] & size_m1) != '0);
    assign pkt_bad   = EW'(size_q[s]) < {1'b0, pkt_q[s], 1'b0};
    assign align_bad = (SZW'(base_q[s]) & size_m1) != '0;
    assign over_bad  = end_w[s] > EW'(HALF_BYTES);

    always_comb begin
      ovl_bad = 1'b0;
      for (int j = 0; j < NUM_EP; j++) begin
        if ((DBASE + j != s) && en_q[DBASE + j] &&
            (EW'(base_q[s]) < end_w[DBASE + j]) &&
            (EW'(base_q[DBASE + j]) < end_w[s]))
          ovl_bad = 1'b1;
      end
    end

    assign slot_err[s]  = en_q[s] &&
                          (type_bad || pow2_bad || pkt_bad || align_bad || over_bad || ovl_bad);
    assign slot_en[s]   = en_q[s];
    assign slot_size[s] = size_q[s][PW-1:0];
    assign slot_base[s] = base_q[s];
  end
endmodule

// File: rtl/epbuf_ptr.sv
module epbuf_ptr #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          usable,
  input  logic [PW-1:0] size,
  input  logic          wr,
  input  logic          rd,
  output logic [PW-1:0] wp,
  output logic [PW-1:0] rp,
  output logic [PW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf,
  output logic          wr_ok,
  output logic          rd_ok
);
  assign level = wp - rp;
  assign empty = (level == '0);
  assign full  = usable && (level == size);
  assign wr_ok = wr && usable && !full && !clr;
  assign rd_ok = rd && usable && !empty && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      ovf <= 1'b0;
      udf <= 1'b0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      wp  <= wp + PW'(wr_ok);
      rp  <= rp + PW'(rd_ok);
      ovf <= ovf | (wr && usable && full);
      udf <= udf | (rd && usable && empty);
    end
  end

  // R10
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= size);

  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !clr) |=> (wp == $past(wp)));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0 && !ovf && !udf));
endmodule

// File: rtl/epbuf_mgr.sv
module epbuf_mgr #(
  parameter int NUM_EP = 8,
  parameter int HALF_BYTES = 512,
  parameter int DW = 8,
  localparam int AW = $clog2(HALF_BYTES),
  localparam int PW = AW + 1,
  localparam int SZW = AW + 2,
  localparam int EPW = $clog2(NUM_EP),
  localparam int SLOTS = 2 * NUM_EP,
  localparam int SW = EPW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_dir,
  input  logic [EPW-1:0]   cfg_ep,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_type,
  input  logic [PW-1:0]    cfg_maxpkt,
  input  logic [SZW-1:0]   cfg_size,
  input  logic [AW-1:0]    cfg_base,
  input  logic             wr_en,
  input  logic             wr_dir,
  input  logic [EPW-1:0]   wr_ep,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic             rd_dir,
  input  logic [EPW-1:0]   rd_ep,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             stat_dir,
  input  logic [EPW-1:0]   stat_ep,
  output logic [PW-1:0]    stat_level,
  output logic [SLOTS-1:0] fifo_full,
  output logic [SLOTS-1:0] fifo_empty,
  output logic [SLOTS-1:0] ovf_flag,
  output logic [SLOTS-1:0] udf_flag,
  output logic [SLOTS-1:0] cfg_err
);
  logic [SW-1:0] cfg_slot, wr_slot, rd_slot;
  assign cfg_slot = {cfg_dir, cfg_ep};
  assign wr_slot  = {wr_dir, wr_ep};
  assign rd_slot  = {rd_dir, rd_ep};

  logic          slot_en   [SLOTS];
  logic [PW-1:0] slot_size [SLOTS];
  logic [AW-1:0] slot_base [SLOTS];
  logic          slot_err  [SLOTS];

  epbuf_cfg #(.NUM_EP(NUM_EP), .HALF_BYTES(HALF_BYTES)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_slot  (cfg_slot),
    .cfg_en    (cfg_en),
    .cfg_type  (cfg_type),
    .cfg_maxpkt(cfg_maxpkt),
    .cfg_size  (cfg_size),
    .cfg_base  (cfg_base),
    .slot_en   (slot_en),
    .slot_size (slot_size),
    .slot_base (slot_base),
    .slot_err  (slot_err)
  );

  logic [PW-1:0]    wp_a [SLOTS];
  logic [PW-1:0]    rp_a [SLOTS];
  logic [PW-1:0]    lvl_a [SLOTS];
  logic [SLOTS-1:0] wr_ok_v, rd_ok_v;

  for (genvar s = 0; s < SLOTS; s++) begin : g_ptr
    logic clr_s, wr_s, rd_s, usable_s;
    assign clr_s    = cfg_valid && (cfg_slot == SW'(s));
    assign wr_s     = wr_en && (wr_slot == SW'(s));
    assign rd_s     = rd_en && (rd_slot == SW'(s));
    assign usable_s = slot_en[s] && !slot_err[s];
    assign cfg_err[s] = slot_err[s];

    epbuf_ptr #(.PW(PW)) i_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_s),
      .usable (usable_s),
      .size   (slot_size[s]),
      .wr     (wr_s),
      .rd     (rd_s),
      .wp     (wp_a[s]),
      .rp     (rp_a[s]),
      .level  (lvl_a[s]),
      .full   (fifo_full[s]),
      .empty  (fifo_empty[s]),
      .ovf    (ovf_flag[s]),
      .udf    (udf_flag[s]),
      .wr_ok  (wr_ok_v[s]),
      .rd_ok  (rd_ok_v[s])
    );
  end

  logic          wr_any, rd_any;
  logic [PW-1:0] wr_phys, rd_phys;
  assign wr_any  = |wr_ok_v;
  assign rd_any  = |rd_ok_v;
  assign wr_phys = PW'(slot_base[wr_slot]) | (wp_a[wr_slot] & (slot_size[wr_slot] - PW'(1)));
  assign rd_phys = PW'(slot_base[rd_slot]) | (rp_a[rd_slot] & (slot_size[rd_slot] - PW'(1)));

  epbuf_ram #(.DW(DW), .RAW(AW + 1)) i_ram (
    .clk   (clk),
    .we    (wr_any),
    .waddr ({wr_dir, wr_phys[AW-1:0]}),
    .wdata (wr_data),
    .re    (rd_any),
    .raddr ({rd_dir, rd_phys[AW-1:0]}),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_any;
  end

  assign stat_level = lvl_a[{stat_dir, stat_ep}];

  // R9
  region_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any |-> !wr_phys[PW-1]) and (rd_any |-> !rd_phys[PW-1]));

  // R3
  ep0_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ep == '0 && cfg_en && cfg_type != 2'd0) |=> cfg_err[$past(cfg_slot)]);

  // R12
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !slot_en[wr_slot]) |-> !wr_any);

  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty[rd_slot]) |=> !rd_valid);
endmodule

// File: tb/test_epbuf_mgr.sv
`timescale 1ns/1ps
module test_epbuf_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 0, cfg_dir = 0, cfg_en = 0;
  logic [2:0] cfg_ep = 0;
  logic [1:0] cfg_type = 0;
  logic [9:0] cfg_maxpkt = 0;
  logic [10:0] cfg_size = 0;
  logic [8:0] cfg_base = 0;
  logic wr_en = 0, wr_dir = 0;
  logic [2:0] wr_ep = 0;
  logic [7:0] wr_data = 0;
  logic rd_en = 0, rd_dir = 0;
  logic [2:0] rd_ep = 0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic stat_dir = 0;
  logic [2:0] stat_ep = 0;
  logic [9:0] stat_level;
  logic [15:0] fifo_full, fifo_empty, ovf_flag, udf_flag, cfg_err;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  epbuf_mgr i_epbuf_mgr (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_dir(cfg_dir), .cfg_ep(cfg_ep), .cfg_en(cfg_en),
    .cfg_type(cfg_type), .cfg_maxpkt(cfg_maxpkt), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .wr_en(wr_en), .wr_dir(wr_dir), .wr_ep(wr_ep), .wr_data(wr_data),
    .rd_en(rd_en), .rd_dir(rd_dir), .rd_ep(rd_ep), .rd_valid(rd_valid), .rd_data(rd_data),
    .stat_dir(stat_dir), .stat_ep(stat_ep), .stat_level(stat_level),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf_flag(ovf_flag),
    .udf_flag(udf_flag), .cfg_err(cfg_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_w(bit d, int ep, bit en, int ty, int mp, int sz, int b);
    @(negedge clk);
    cfg_valid = 1; cfg_dir = d; cfg_ep = 3'(ep); cfg_en = en; cfg_type = 2'(ty);
    cfg_maxpkt = 10'(mp); cfg_size = 11'(sz); cfg_base = 9'(b);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic push(bit d, int ep, logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_dir = d; wr_ep = 3'(ep); wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pop(bit d, int ep, output logic [7:0] v, output logic vld);
    @(negedge clk);
    rd_en = 1; rd_dir = d; rd_ep = 3'(ep);
    @(negedge clk);
    rd_en = 0;
    v = rd_data; vld = rd_valid;
  endtask

  function automatic logic [9:0] level_of(bit d, int ep);
    stat_dir = d; stat_ep = 3'(ep);
    return 10'(0);
  endfunction

  task automatic get_level(bit d, int ep, output logic [9:0] l);
    void'(level_of(d, ep));
    #0.5;
    l = stat_level;
  endtask

  task automatic t_reset();
    chk("R1", "full", 32'(fifo_full), 32'h0);
    chk("R1", "empty", 32'(fifo_empty), 32'hFFFF);
    chk("R1", "ovf", 32'(ovf_flag), 32'h0);
    chk("R1", "udf", 32'(udf_flag), 32'h0);
    chk("R1", "cfg_err", 32'(cfg_err), 32'h0);
    chk("R1", "rd_valid", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_cfg_rules();
    cfg_w(0, 0, 1, 1, 8, 16, 0);
    chk("R3", "ep0 iso err", 32'(cfg_err[0]), 1);
    cfg_w(0, 0, 1, 0, 8, 16, 0);
    chk("R3", "ep0 ctrl ok", 32'(cfg_err[0]), 0);
    cfg_w(1, 0, 1, 2, 8, 16, 0);
    chk("R3", "rx ep0 bulk err", 32'(cfg_err[8]), 1);
    cfg_w(1, 0, 0, 0, 8, 16, 0);
    cfg_w(0, 1, 1, 2, 8, 48, 256);
    chk("R4", "size 48 err", 32'(cfg_err[1]), 1);
    cfg_w(0, 1, 1, 2, 8, 0, 256);
    chk("R4", "size 0 err", 32'(cfg_err[1]), 1);
    cfg_w(0, 1, 1, 2, 64, 64, 256);
    chk("R5", "size<2*pkt err", 32'(cfg_err[1]), 1);
    cfg_w(0, 1, 1, 2, 32, 64, 256);
    chk("R5", "size==2*pkt ok", 32'(cfg_err[1]), 0);
    cfg_w(0, 1, 1, 2, 8, 64, 288);
    chk("R6", "misaligned err", 32'(cfg_err[1]), 1);
    cfg_w(0, 1, 1, 2, 8, 1024, 0);
    chk("R6", "overrun err", 32'(cfg_err[1]), 1);
    cfg_w(0, 1, 1, 2, 8, 256, 256);
    chk("R6", "end at 512 ok", 32'(cfg_err[1]), 0);
    cfg_w(0, 1, 1, 2, 8, 64, 0);
    chk("R7", "overlap pair", 32'(cfg_err[1:0]), 2'b11);
    cfg_w(1, 1, 1, 2, 8, 64, 0);
    chk("R7", "other dir no conflict", 32'(cfg_err[9]), 0);
    cfg_w(0, 1, 1, 2, 8, 16, 16);
    chk("R7", "touching ranges ok", 32'(cfg_err[1:0]), 2'b00);
    cfg_w(0, 1, 0, 2, 8, 16, 16);
    cfg_w(1, 1, 0, 2, 8, 64, 0);
    chk("R7", "all clear", 32'(cfg_err), 0);
  endtask

  task automatic t_order();
    logic [7:0] v; logic vld; logic [9:0] l;
    cfg_w(0, 2, 1, 2, 8, 16, 64);
    for (int i = 0; i < 5; i++) push(0, 2, 8'(8'h11 + i));
    get_level(0, 2, l);
    chk("R10", "level 5", 32'(l), 5);
    chk("R10", "not empty", 32'(fifo_empty[2]), 0);
    for (int i = 0; i < 5; i++) begin
      pop(0, 2, v, vld);
      chk("R8", "valid", 32'(vld), 1);
      chk("R8", "order", 32'(v), 32'(8'h11 + i));
    end
    chk("R10", "empty again", 32'(fifo_empty[2]), 1);
  endtask

  task automatic t_wrap();
    logic [7:0] v; logic vld; logic [9:0] l;
    cfg_w(0, 3, 1, 2, 8, 16, 80);
    for (int i = 0; i < 4; i++) push(0, 3, 8'(8'hC0 + i));
    for (int i = 0; i < 16; i++) push(0, 2, 8'(8'h40 + i));
    get_level(0, 2, l);
    chk("R10", "level 16", 32'(l), 16);
    chk("R10", "full", 32'(fifo_full[2]), 1);
    chk("R11", "no ovf yet", 32'(ovf_flag[2]), 0);
    push(0, 2, 8'hFF);
    chk("R11", "ovf set", 32'(ovf_flag[2]), 1);
    get_level(0, 2, l);
    chk("R11", "level held", 32'(l), 16);
    for (int i = 0; i < 16; i++) begin
      pop(0, 2, v, vld);
      chk("R9", "wrapped data", 32'({vld, v}), 32'({1'b1, 8'(8'h40 + i)}));
    end
    pop(0, 2, v, vld);
    chk("R11", "empty read no valid", 32'(vld), 0);
    chk("R11", "udf set", 32'(udf_flag[2]), 1);
    chk("R11", "ovf still set", 32'(ovf_flag[2]), 1);
    for (int i = 0; i < 4; i++) begin
      pop(0, 3, v, vld);
      chk("R9", "neighbour intact", 32'({vld, v}), 32'({1'b1, 8'(8'hC0 + i)}));
    end
  endtask

  task automatic t_ignore();
    logic [7:0] v; logic vld; logic [9:0] l;
    push(1, 5, 8'h77);
    get_level(1, 5, l);
    chk("R12", "disabled write level", 32'(l), 0);
    chk("R12", "disabled write no ovf", 32'(ovf_flag[13]), 0);
    pop(1, 5, v, vld);
    chk("R12", "disabled read no valid", 32'(vld), 0);
    chk("R12", "disabled read no udf", 32'(udf_flag[13]), 0);
    cfg_w(1, 5, 1, 2, 8, 48, 0);
    push(1, 5, 8'h78);
    get_level(1, 5, l);
    chk("R12", "error slot write level", 32'(l), 0);
    chk("R12", "error slot empty", 32'(fifo_empty[13]), 1);
    cfg_w(1, 5, 0, 2, 8, 48, 0);
  endtask

  task automatic t_reconfig();
    logic [9:0] l;
    push(0, 2, 8'h01);
    push(0, 2, 8'h02);
    get_level(0, 2, l);
    chk("R2", "level before", 32'(l), 2);
    cfg_w(0, 2, 1, 2, 8, 32, 96);
    get_level(0, 2, l);
    chk("R2", "level cleared", 32'(l), 0);
    chk("R2", "flags cleared", 32'({ovf_flag[2], udf_flag[2]}), 0);
    chk("R2", "new cfg ok", 32'(cfg_err[2]), 0);
  endtask

  task automatic t_dirs();
    logic [7:0] v; logic vld; logic [9:0] l;
    cfg_w(0, 6, 1, 3, 8, 32, 128);
    cfg_w(1, 6, 1, 3, 8, 32, 128);
    for (int i = 0; i < 3; i++) push(0, 6, 8'(8'hA1 + i));
    push(1, 6, 8'hB1);
    get_level(0, 6, l);
    chk("R13", "tx level", 32'(l), 3);
    get_level(1, 6, l);
    chk("R13", "rx level", 32'(l), 1);
    pop(1, 6, v, vld);
    chk("R13", "rx data", 32'({vld, v}), 32'({1'b1, 8'hB1}));
    pop(0, 6, v, vld);
    chk("R13", "tx data", 32'({vld, v}), 32'({1'b1, 8'hA1}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg_rules();
    t_order();
    t_wrap();
    t_ignore();
    t_reconfig();
    t_dirs();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule